// File: doc/BRIEF.md
# Image Sensor Piecewise Linearization Unit

This block is a streaming stage in a pixel pipeline. It corrects the nonlinear response of an image sensor. Each valid cycle it accepts one unsigned 16-bit pixel and scales it by a programmable factor. The scaled value then selects a segment of a 192-entry correction curve. The two samples that bound that segment are blended with a linear weight. The blended correction is a signed offset. It is shifted left by a programmable amount, added to the original pixel, and reduced to an unsigned 12-bit result that saturates at both ends.

The curve can be indexed in two ways. In piecewise mode, seven regions of unequal density give fine steps in the darkest and brightest parts of the range. In uniform mode there are 128 equal segments. Samples are stored in two banks: even entries in one and odd entries in the other. This lets both neighbours of a segment be fetched in the same cycle.

Software loads the curve through a simple write port while no frame is streaming. When correction is turned off, the block passes the upper 12 bits of each pixel through with the same latency.

Top module: `pix_linearizer`

## Requirements
- R1: After reset, `out_valid` is 0, `out_pix` is 0, and every curve sample reads as 0.
- R2: `out_valid` repeats `in_valid` four clock edges later, counting the edge that samples the input as the first. Results leave the block in input order.
- R3: With `cfg_enable` = 0, `out_pix` equals `in_pix[15:4]`.
- R4: The scaled value is min(floor(`in_pix` × `cfg_scale` / 1024), 65535). A `cfg_scale` of 1024 is unity.
- R5: With `cfg_uniform` = 0 the region is decoded from the scaled value s. The address a and the 8-bit weight f are:
  - s[15:11]=0: a=s[10:6], f={s[5:0],00}
  - s[15:11]=1: a=32+s[10:9], f=s[8:1]
  - s[15:12]=1: a=36+s[11:10], f=s[9:2]
  - s[15:13]=1: a=40+s[12:11], f=s[10:3]
  - s[15:14]=01: a=44+s[13:12], f=s[11:4]
  - s[15:14]=10: a=48+s[13:10], f=s[9:2]
  - s[15:14]=11: a=64+s[13:7], f={s[6:0],0}
- R6: With `cfg_uniform` = 1 the address is s[15:9] and the weight is s[8:1].
- R7: A write with `tbl_we` = 1 stores the 10-bit two's-complement `tbl_data` as sample `tbl_addr` (0..191). Bit 0 of the address picks the bank: 0 for even and 1 for odd. Bits [7:1] give the word within that bank.
- R8: A write presented while `frame_active` = 1 leaves every sample unchanged.
- R9: The correction is floor((lo×256 + (hi−lo)×f + 128) / 256). Here lo is the sample at the address and hi is the sample at the address plus one. The result always lies between lo and hi.
- R10: When the address is the top of the active range (191 in piecewise mode, 127 in uniform mode), hi is taken equal to lo.
- R11: With correction on, the output is floor((`in_pix` + correction × 2^`cfg_shift`) / 16).
- R12: A negative sum gives 0, and a quotient above 4095 gives 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1 applies the correction, 0 passes the upper bits through |
| cfg_uniform | input | 1 | 1 selects uniform segments, 0 selects the seven-region layout |
| cfg_scale | input | 11 | Input gain with 10 fractional bits |
| cfg_shift | input | 3 | Left shift applied to the correction |
| frame_active | input | 1 | High while a frame streams; locks the curve |
| tbl_we | input | 1 | Curve write strobe |
| tbl_addr | input | 8 | Curve sample index |
| tbl_data | input | 10 | Signed curve sample |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 16 | Input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 12 | Corrected pixel |

## Verification
Each result is due exactly four clock edges after the edge that samples its pixel. The bench drives inputs on the falling edge and stores the expected value and qualifier in a history ring at that moment. Four falling edges later it compares both ports with that entry. Curve writes take effect at the next rising edge. Configuration is read as the pixel moves through the stages. For both reasons, the bench lets the pipeline drain with idle cycles before it changes configuration or loads samples. Each stored expectation therefore matches the state the pixel actually meets.

// File: rtl/pix_lin_pkg.sv
package pix_lin_pkg;

    localparam int LIN_PIX_W   = 16;
    localparam int LIN_OUT_W   = 12;
    localparam int LIN_ENT_W   = 10;
    localparam int LIN_DEPTH   = 192;
    localparam int LIN_SCL_W   = 11;
    localparam int LIN_SCL_FR  = 10;
    localparam int LIN_FRAC_W  = 8;
    localparam int LIN_SFT_W   = 3;

    // Which part of the curve a scaled pixel falls into
    typedef enum logic [2:0] {
        SEG_DARK   = 3'd0,
        SEG_LOW1   = 3'd1,
        SEG_LOW2   = 3'd2,
        SEG_LOW3   = 3'd3,
        SEG_MID    = 3'd4,
        SEG_UPPER  = 3'd5,
        SEG_BRIGHT = 3'd6,
        SEG_EVEN   = 3'd7
    } seg_kind_e;

endpackage

// File: rtl/lin_region_decode.sv
module lin_region_decode
    import pix_lin_pkg::*;
#(
    parameter int PIX_W  = LIN_PIX_W,
    parameter int ADDR_W = 8,
    parameter int FRAC_W = LIN_FRAC_W
) (
    input  logic [PIX_W-1:0]  val,
    input  logic              uniform,
    output logic [ADDR_W-1:0] addr,
    output logic [FRAC_W-1:0] frac,
    output logic              at_top
);
    localparam logic [ADDR_W-1:0] TOP_SPARSE  = ADDR_W'(191);
    localparam logic [ADDR_W-1:0] TOP_UNIFORM = ADDR_W'(127);

    seg_kind_e kind;

    always_comb begin
        if (uniform)                 kind = SEG_EVEN;
        else if (val[15:14] == 2'b11) kind = SEG_BRIGHT;
        else if (val[15:14] == 2'b10) kind = SEG_UPPER;
        else if (val[15:14] == 2'b01) kind = SEG_MID;
        else if (val[13])             kind = SEG_LOW3;
        else if (val[12])             kind = SEG_LOW2;
        else if (val[11])             kind = SEG_LOW1;
        else                          kind = SEG_DARK;
    end

    always_comb begin
        addr = '0;
        frac = '0;
        unique case (kind)
            SEG_EVEN: begin
                addr = ADDR_W'(val[15:9]);
                frac = val[8:1];
            end
            SEG_BRIGHT: begin
                addr = ADDR_W'(64) + ADDR_W'(val[13:7]);
                frac = {val[6:0], 1'b0};
            end
            SEG_UPPER: begin
                addr = ADDR_W'(48) + ADDR_W'(val[13:10]);
                frac = val[9:2];
            end
            SEG_MID: begin
                addr = ADDR_W'(44) + ADDR_W'(val[13:12]);
                frac = val[11:4];
            end
            SEG_LOW3: begin
                addr = ADDR_W'(40) + ADDR_W'(val[12:11]);
                frac = val[10:3];
            end
            SEG_LOW2: begin
                addr = ADDR_W'(36) + ADDR_W'(val[11:10]);
                frac = val[9:2];
            end
            SEG_LOW1: begin
                addr = ADDR_W'(32) + ADDR_W'(val[10:9]);
                frac = val[8:1];
            end
            default: begin
                addr = ADDR_W'(val[10:6]);
                frac = {val[5:0], 2'b00};
            end
        endcase
        at_top = uniform ? (addr == TOP_UNIFORM) : (addr == TOP_SPARSE);
    end

endmodule

// File: rtl/lin_dual_bank.sv
module lin_dual_bank #(
    parameter int DEPTH  = 192,
    parameter int W      = 10,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_top,
    output logic [W-1:0]  rd_lo,
    output logic [W-1:0]  rd_hi
);
    localparam int BD  = DEPTH / 2;
    localparam int BAW = AW - 1;

    logic [1:0][BD-1:0][W-1:0] mem_d, mem_q;

    logic [BAW-1:0] idx_odd;
    logic [BAW:0]   idx_even_w;
    logic [BAW-1:0] idx_even;
    logic [W-1:0]   even_w, odd_w;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && !lock && (wr_addr < AW'(DEPTH)))
            mem_d[wr_addr[0]][wr_addr[AW-1:1]] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // Address a and a+1 always land in opposite banks
    always_comb begin
        idx_odd    = rd_addr[AW-1:1];
        idx_even_w = {1'b0, idx_odd} + (BAW+1)'(rd_addr[0]);
        idx_even   = (idx_even_w >= (BAW+1)'(BD)) ? '0 : idx_even_w[BAW-1:0];
        even_w     = mem_q[0][idx_even];
        odd_w      = mem_q[1][idx_odd];
        rd_lo      = rd_addr[0] ? odd_w : even_w;
        rd_hi      = rd_top ? rd_lo : (rd_addr[0] ? even_w : odd_w);
    end

    assert_locked_curve_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en) |=> $stable(mem_q));

    assert_even_bank_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock && !wr_addr[0]) |=> $stable(mem_q[1]));

    assert_odd_bank_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lock && wr_addr[0]) |=> $stable(mem_q[0]));

endmodule

// File: rtl/lin_interp.sv
module lin_interp #(
    parameter int W  = 10,
    parameter int FW = 8
) (
    input  logic [W-1:0]  lo,
    input  logic [W-1:0]  hi,
    input  logic [FW-1:0] frac,
    output logic [W:0]    corr
);
    localparam int XW = W + FW + 3;

    logic signed [XW-1:0] lo_x, hi_x, diff, fr_x, half_c, acc;

    always_comb begin
        lo_x   = XW'($signed(lo));
        hi_x   = XW'($signed(hi));
        diff   = hi_x - lo_x;
        fr_x   = $signed({{(XW-FW){1'b0}}, frac});
        half_c = '0;
        half_c[FW-1] = 1'b1;
        acc    = (lo_x <<< FW) + (diff * fr_x) + half_c;
        corr   = acc[FW+W:FW];
    end

endmodule

// File: rtl/lin_finish.sv
module lin_finish #(
    parameter int PIX_W = 16,
    parameter int OUT_W = 12,
    parameter int CW    = 11,
    parameter int SFT_W = 3
) (
    input  logic             bypass,
    input  logic [PIX_W-1:0] pix,
    input  logic [CW-1:0]    corr,
    input  logic [SFT_W-1:0] shift,
    output logic [OUT_W-1:0] result
);
    localparam int MAX_SH = (1 << SFT_W) - 1;
    localparam int BIGGER = (PIX_W > CW + MAX_SH) ? PIX_W : CW + MAX_SH;
    localparam int SW     = BIGGER + 2;
    localparam int DROP   = PIX_W - OUT_W;

    logic signed [SW-1:0] pix_x, corr_x, sum;

    always_comb begin
        pix_x  = $signed({{(SW-PIX_W){1'b0}}, pix});
        corr_x = SW'($signed(corr));
        sum    = pix_x + (corr_x <<< shift);
        if (bypass)
            result = pix[PIX_W-1:DROP];
        else if (sum[SW-1])
            result = '0;
        else if (|sum[SW-2:PIX_W])
            result = '1;
        else
            result = sum[PIX_W-1:DROP];
    end

endmodule

// File: rtl/pix_linearizer.sv
module pix_linearizer
    import pix_lin_pkg::*;
#(
    parameter int PIX_W  = LIN_PIX_W,
    parameter int OUT_W  = LIN_OUT_W,
    parameter int ENT_W  = LIN_ENT_W,
    parameter int DEPTH  = LIN_DEPTH,
    parameter int SCL_W  = LIN_SCL_W,
    parameter int SCL_FR = LIN_SCL_FR,
    parameter int FRAC_W = LIN_FRAC_W,
    parameter int SFT_W  = LIN_SFT_W,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_uniform,
    input  logic [SCL_W-1:0]  cfg_scale,
    input  logic [SFT_W-1:0]  cfg_shift,
    input  logic              frame_active,
    input  logic              tbl_we,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [ENT_W-1:0]  tbl_data,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_pix
);
    localparam int PROD_W = PIX_W + SCL_W;
    localparam int CW     = ENT_W + 1;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
        logic [PIX_W-1:0] scaled;
    } st_scale_t;

    typedef struct packed {
        logic              vld;
        logic [PIX_W-1:0]  pix;
        logic [ENT_W-1:0]  lo;
        logic [ENT_W-1:0]  hi;
        logic [FRAC_W-1:0] frac;
    } st_fetch_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] pix;
        logic [CW-1:0]    corr;
    } st_blend_t;

    typedef struct packed {
        st_scale_t        sc;
        st_fetch_t        fe;
        st_blend_t        bl;
        logic             ovld;
        logic [OUT_W-1:0] opix;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [PROD_W-1:0] prod, prod_sh;
    logic [PIX_W-1:0]  scaled_sat;
    logic [ADDR_W-1:0] seg_addr;
    logic [FRAC_W-1:0] seg_frac;
    logic              seg_top;
    logic [ENT_W-1:0]  smp_lo, smp_hi;
    logic [CW-1:0]     blend_corr;
    logic [OUT_W-1:0]  fin_pix;

    lin_region_decode #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_dec (
        .val     (pipe_q.sc.scaled),
        .uniform (cfg_uniform),
        .addr    (seg_addr),
        .frac    (seg_frac),
        .at_top  (seg_top)
    );

    lin_dual_bank #(.DEPTH(DEPTH), .W(ENT_W), .AW(ADDR_W)) u_curve (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (frame_active),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .rd_addr (seg_addr),
        .rd_top  (seg_top),
        .rd_lo   (smp_lo),
        .rd_hi   (smp_hi)
    );

    lin_interp #(.W(ENT_W), .FW(FRAC_W)) u_blend (
        .lo   (pipe_q.fe.lo),
        .hi   (pipe_q.fe.hi),
        .frac (pipe_q.fe.frac),
        .corr (blend_corr)
    );

    lin_finish #(.PIX_W(PIX_W), .OUT_W(OUT_W), .CW(CW), .SFT_W(SFT_W)) u_fin (
        .bypass (!cfg_enable),
        .pix    (pipe_q.bl.pix),
        .corr   (pipe_q.bl.corr),
        .shift  (cfg_shift),
        .result (fin_pix)
    );

    always_comb begin
        prod       = PROD_W'(in_pix) * PROD_W'(cfg_scale);
        prod_sh    = prod >> SCL_FR;
        scaled_sat = (|prod_sh[PROD_W-1:PIX_W]) ? '1 : prod_sh[PIX_W-1:0];

        pipe_d = pipe_q;

        pipe_d.sc.vld    = in_valid;
        pipe_d.sc.pix    = in_pix;
        pipe_d.sc.scaled = scaled_sat;

        pipe_d.fe.vld  = pipe_q.sc.vld;
        pipe_d.fe.pix  = pipe_q.sc.pix;
        pipe_d.fe.lo   = smp_lo;
        pipe_d.fe.hi   = smp_hi;
        pipe_d.fe.frac = seg_frac;

        pipe_d.bl.vld  = pipe_q.fe.vld;
        pipe_d.bl.pix  = pipe_q.fe.pix;
        pipe_d.bl.corr = blend_corr;

        pipe_d.ovld = pipe_q.bl.vld;
        if (pipe_q.bl.vld) pipe_d.opix = fin_pix;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.ovld;
    assign out_pix   = pipe_q.opix;

    // Edge count since reset, used to keep lookback properties inside reset history
    logic [2:0] age_d, age_q;

    always_comb age_d = (age_q == 3'd7) ? age_q : age_q + 3'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    logic signed [CW-1:0] fe_lo_x, fe_hi_x, bl_corr_x;
    assign fe_lo_x   = CW'($signed(pipe_q.fe.lo));
    assign fe_hi_x   = CW'($signed(pipe_q.fe.hi));
    assign bl_corr_x = $signed(pipe_q.bl.corr);

    assert_latency_four_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4 && out_valid && !$past(cfg_enable))
            |-> (out_pix == $past(in_pix[PIX_W-1:PIX_W-OUT_W], 4)));

    assert_blend_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.fe.vld |=>
            ((bl_corr_x >= $past(fe_lo_x) && bl_corr_x <= $past(fe_hi_x)) ||
             (bl_corr_x >= $past(fe_hi_x) && bl_corr_x <= $past(fe_lo_x))));

endmodule

// File: tb/tb_pix_linearizer.sv
module tb_pix_linearizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_uniform = 1'b0;
    logic [10:0] cfg_scale = 11'd1024;
    logic [2:0]  cfg_shift = 3'd0;
    logic        frame_active = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_addr = '0;
    logic [9:0]  tbl_data = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_pix = '0;
    logic        out_valid;
    logic [11:0] out_pix;

    always #2.5 clk = ~clk;

    pix_linearizer dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_uniform(cfg_uniform),
        .cfg_scale(cfg_scale), .cfg_shift(cfg_shift), .frame_active(frame_active),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .in_valid(in_valid), .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    int    curve[192];
    logic  h_vld[16];
    int    h_exp[16];
    string h_tag[16];
    bit    done = 0;

    function automatic int ref_out(int pix);
        int sc, a, f, lo, hi, it, corr, sum, q;
        bit top;
        if (!cfg_enable) return pix >> 4;
        sc = (pix * int'(cfg_scale)) >> 10;
        if (sc > 65535) sc = 65535;
        if (cfg_uniform) begin a = sc >> 9; f = (sc >> 1) & 255; end
        else if (sc >= 49152) begin a = 64 + ((sc >> 7) & 127); f = (sc & 127) * 2; end
        else if (sc >= 32768) begin a = 48 + ((sc >> 10) & 15); f = (sc >> 2) & 255; end
        else if (sc >= 16384) begin a = 44 + ((sc >> 12) & 3); f = (sc >> 4) & 255; end
        else if (sc >= 8192)  begin a = 40 + ((sc >> 11) & 3); f = (sc >> 3) & 255; end
        else if (sc >= 4096)  begin a = 36 + ((sc >> 10) & 3); f = (sc >> 2) & 255; end
        else if (sc >= 2048)  begin a = 32 + ((sc >> 9) & 3);  f = (sc >> 1) & 255; end
        else                  begin a = sc >> 6;               f = (sc & 63) * 4; end
        top  = cfg_uniform ? (a == 127) : (a == 191);
        lo   = curve[a];
        hi   = top ? lo : curve[a + 1];
        it   = lo * 256 + (hi - lo) * f + 128;
        corr = it >>> 8;
        sum  = pix + corr * (1 << cfg_shift);
        if (sum < 0) return 0;
        q = sum >>> 4;
        if (q > 4095) return 4095;
        return q;
    endfunction

    task automatic compare();
        int k;
        k = (cyc - 4) & 15;
        n_cmp++;
        if (out_valid !== h_vld[k]) begin
            n_bad++;
            $display("FAIL %s (R2 valid) cycle %0d: out_valid=%0b expected=%0b",
                     h_tag[k], cyc, out_valid, h_vld[k]);
        end
        if (h_vld[k]) begin
            n_cmp++;
            if (int'(out_pix) != h_exp[k]) begin
                n_bad++;
                $display("FAIL %s cycle %0d: out_pix=%0d expected=%0d",
                         h_tag[k], cyc, out_pix, h_exp[k]);
            end
        end
    endtask

    task automatic step(input logic v, input int p, input string tag);
        @(negedge clk);
        compare();
        tbl_we   = 1'b0;
        in_valid = v;
        in_pix   = 16'(p);
        h_vld[cyc & 15] = v;
        h_exp[cyc & 15] = v ? ref_out(p) : 0;
        h_tag[cyc & 15] = tag;
        cyc++;
    endtask

    task automatic write_smp(input int a, input int val);
        @(negedge clk);
        compare();
        in_valid = 1'b0;
        tbl_we   = 1'b1;
        tbl_addr = 8'(a);
        tbl_data = 10'(val);
        h_vld[cyc & 15] = 1'b0;
        h_exp[cyc & 15] = 0;
        h_tag[cyc & 15] = "R7";
        cyc++;
        if (!frame_active) curve[a] = val;
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) step(1'b0, 0, "R2");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin h_vld[i] = 1'b0; h_exp[i] = 0; h_tag[i] = "R1"; end
        for (int i = 0; i < 192; i++) curve[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at the ports
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || out_pix !== 12'd0) begin
            n_bad++;
            $display("FAIL R1 reset: valid=%0b pix=%0d expected 0/0", out_valid, out_pix);
        end
        // R1: cleared curve, correction on, zero offset
        cfg_enable = 1'b1;
        step(1'b1, 16'h1234, "R1");
        step(1'b1, 16'hFFFF, "R1");
        drain();

        // R3: pass-through with correction off
        cfg_enable = 1'b0;
        for (int i = 0; i < 20; i++) step(1'b1, int'($urandom_range(0, 65535)), "R3");
        drain();

        // R7: load the curve
        for (int i = 0; i < 192; i++) write_smp(i, ((i * 37 + 11) % 1024) - 512);
        drain();

        // R5: each piecewise region, unity gain
        cfg_enable = 1'b1; cfg_uniform = 1'b0; cfg_scale = 11'd1024; cfg_shift = 3'd2;
        for (int i = 0; i < 64; i++) step(1'b1, i * 37, "R5");
        for (int i = 0; i < 64; i++) step(1'b1, 2048 + i * 97, "R5");
        for (int i = 0; i < 64; i++) step(1'b1, i * 1021, "R5");
        for (int i = 0; i < 40; i++) step(1'b1, int'($urandom_range(0, 65535)), "R11");
        step(1'b1, 2047, "R5"); step(1'b1, 2048, "R5"); step(1'b1, 4095, "R5");
        step(1'b1, 4096, "R5"); step(1'b1, 16383, "R5"); step(1'b1, 49152, "R5");
        drain();

        // R4: gain above and below unity, including saturation
        cfg_scale = 11'd2047;
        for (int i = 0; i < 30; i++) step(1'b1, int'($urandom_range(0, 65535)), "R4");
        step(1'b1, 65535, "R4");
        drain();
        cfg_scale = 11'd300;
        for (int i = 0; i < 30; i++) step(1'b1, int'($urandom_range(0, 65535)), "R4");
        drain();

        // R6: uniform segments
        cfg_scale = 11'd1024; cfg_uniform = 1'b1; cfg_shift = 3'd5;
        for (int i = 0; i < 60; i++) step(1'b1, int'($urandom_range(0, 65535)), "R6");
        drain();

        // R10: top of each range keeps its neighbour equal
        step(1'b1, 65535, "R10"); step(1'b1, 65024, "R10");
        drain();
        cfg_uniform = 1'b0;
        step(1'b1, 65535, "R10"); step(1'b1, 65471, "R10");
        drain();

        // R9: blending between widely spaced samples
        write_smp(10, 400); write_smp(11, -400);
        drain();
        cfg_shift = 3'd0;
        for (int i = 0; i < 64; i++) step(1'b1, 640 + i, "R9");
        drain();

        // R12: clipping at both ends
        write_smp(190, 511); write_smp(191, 511); write_smp(0, -512); write_smp(1, -512);
        drain();
        cfg_shift = 3'd7;
        step(1'b1, 65535, "R12"); step(1'b1, 16, "R12"); step(1'b1, 0, "R12");
        drain();

        // R8: writes during a frame leave the curve alone
        cfg_shift = 3'd3;
        frame_active = 1'b1;
        write_smp(100, 300); write_smp(101, -300);
        drain();
        for (int i = 0; i < 16; i++) step(1'b1, 49152 + 4608 + i * 8, "R8");
        drain();
        frame_active = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule